// File: doc/BRIEF.md
# Scan Gateway Pulse and Status Data Registers

This block holds the small device-specific test data registers of a multi-port scan gateway. The gateway's TAP controller and its instruction register sit outside. They hand this block the current 8-bit opcode, one strobe per TAP state of interest, and the serial input bit. The block decodes the opcode and selects one of its registers for the serial return path. That register loads at Capture-DR, shifts towards the LSB in Shift-DR, and acts at Update-DR.

Two of the registers are one bit wide and serve as command triggers. One produces a one-TCK low pulse on a board self-test pin. The other produces a one-TCK low pulse on the test reset line of every local port. Neither touches the gateway's own selection or configuration, so a reset test can be run on the boards behind the ports while the gateway stays addressed. Two other registers give a board-status snapshot taken from input pins, and a per-port enable mask that routes the primary write strobe to each local port. A user-code register, a bypass bit and an identification register complete the set. An active-low local reset input holds every port reset line low and asks the selection logic to fall back to its waiting state.

The clock is TCK. Capture and shift act on the rising edge at the end of a state. Update actions, pulses and new enables take effect on the falling edge inside Update-DR. The reset input `rst` is synchronous and active high.

Top module: `gw_pulse_status_tdr`

## Requirements
- R1: After reset, `self_test_n` is 1, every bit of `port_trst_n` is 1 while `local_rst_n` is 1, and `wr_strobe_oe` is all zeros.
- R2: With opcode 0x9A, Capture-DR loads the 8 `status_pins` into a shift register. That register then shifts out on `tdo_data` LSB first, one bit per Shift-DR cycle.
- R3: With opcode 0x99, a one-bit register is cleared at Capture-DR. If the bit holds 0 at Update-DR, `self_test_n` goes low at the falling edge inside Update-DR and returns high one TCK period later. If a 1 has been shifted in, there is no pulse.
- R4: A self-test or port-reset pulse lasts exactly one TCK period, even when `update_dr` stays high for several cycles.
- R5: With opcode 0x9B, the same one-bit scheme drives every bit of `port_trst_n` low for one TCK period, and `self_test_n` stays high.
- R6: While `local_rst_n` is 0, every bit of `port_trst_n` is 0 and `wait_sel_req` is 1. Once it returns to 1, the lines go high, unless a reset pulse is in progress.
- R7: Opcode 0x98 accesses a 6-bit enable mask. The mask is written at Update-DR and read back at Capture-DR. While bit n is 1, `wr_strobe_oe[n]` is 1 and `wr_strobe_out[n]` follows `wr_strobe_in`. While bit n is 0, both are 0.
- R8: A cycle with `tlr` high clears the enable mask by the falling edge of that cycle.
- R9: Opcode 0x97 selects an 8-bit user-code register that captures all zeros, whatever was shifted in before.
- R10: Opcode 0xFF selects a one-bit bypass register that captures 0 and delays `tdi` by one shift.
- R11: Any opcode other than 0x97, 0x98, 0x99, 0x9A, 0x9B and 0xFF selects a 32-bit identification register that captures `ID_VALUE`.
- R12: An Update-DR under an opcode other than the one owning an action changes neither the enable mask, `self_test_n` nor `port_trst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_opcode | input | 8 | Current instruction opcode |
| capture_dr | input | 1 | High while the TAP is in Capture-DR |
| shift_dr | input | 1 | High while the TAP is in Shift-DR |
| update_dr | input | 1 | High while the TAP is in Update-DR |
| tlr | input | 1 | High while the TAP is in Test-Logic-Reset |
| tdi | input | 1 | Serial test data in |
| status_pins | input | STAT_W | Board status inputs |
| local_rst_n | input | 1 | Active-low local reset input |
| wr_strobe_in | input | 1 | Primary write-strobe signal |
| tdo_data | output | 1 | Serial return data of the selected register |
| self_test_n | output | 1 | Active-low board self-test pulse |
| port_trst_n | output | N_PORTS | Active-low test reset per local port |
| wr_strobe_out | output | N_PORTS | Write strobe routed to each port |
| wr_strobe_oe | output | N_PORTS | Output enable of each port's write strobe |
| wait_sel_req | output | 1 | Request to return to the wait-for-selection state |

## Verification
The port reset pulse from opcode 0x9B and the local reset input both drive `port_trst_n`, so they can land in the same cycle. The bench holds `local_rst_n` low across a whole 0x9B scan, including Update-DR and the cycles after it. It expects the reset lines to stay low for as long as the input is low, without a glitch high when the pulse ends. After release, a second 0x9B scan must still produce a normal single-period pulse, which shows the overlap left no stale pulse state behind.

// File: rtl/gwtdr_pkg.sv
package gwtdr_pkg;

    localparam logic [7:0] OP_BYPASS = 8'hFF;
    localparam logic [7:0] OP_UCODE  = 8'h97;
    localparam logic [7:0] OP_STROBE = 8'h98;
    localparam logic [7:0] OP_STEST  = 8'h99;
    localparam logic [7:0] OP_STATUS = 8'h9A;
    localparam logic [7:0] OP_LRST   = 8'h9B;

    typedef enum logic [2:0] {
        SEL_BYP,
        SEL_ID,
        SEL_UCODE,
        SEL_STATUS,
        SEL_STROBE,
        SEL_STEST,
        SEL_LRST
    } tdr_sel_e;

    localparam int N_PULSE = 2;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } dr_phase_t;

    function automatic tdr_sel_e decode_op(input logic [7:0] op);
        case (op)
            OP_BYPASS: return SEL_BYP;
            OP_UCODE:  return SEL_UCODE;
            OP_STROBE: return SEL_STROBE;
            OP_STEST:  return SEL_STEST;
            OP_STATUS: return SEL_STATUS;
            OP_LRST:   return SEL_LRST;
            default:   return SEL_ID;
        endcase
    endfunction

    function automatic tdr_sel_e pulse_owner(input int idx);
        return (idx == 0) ? SEL_STEST : SEL_LRST;
    endfunction

endpackage

// File: rtl/gwtdr_shift.sv
module gwtdr_shift
    import gwtdr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         tck,
    input  logic         rst,
    input  logic         en,
    input  dr_phase_t    ph,
    input  logic         tdi,
    input  logic [W-1:0] cap_val,
    output logic [W-1:0] q
);

    always_ff @(posedge tck) begin
        if (rst) begin
            q <= '0;
        end else if (en && ph.capture) begin
            q <= cap_val;
        end else if (en && ph.shift) begin
            if (W == 1) q <= tdi;
            else        q <= {tdi, q[W-1:1]};
        end
    end

    p_capture_load_r2: assert property (@(posedge tck) disable iff (rst)
        (en && ph.capture) |=> (q == $past(cap_val)));

endmodule

// File: rtl/gwtdr_pulse.sv
module gwtdr_pulse (
    input  logic tck,
    input  logic rst,
    input  logic sel,
    input  logic update_dr,
    input  logic data_bit,
    output logic pulse_n
);

    logic upd_q;
    logic trig;

    assign trig = sel && update_dr && !data_bit && !upd_q;

    always_ff @(negedge tck) begin
        if (rst) begin
            upd_q   <= 1'b0;
            pulse_n <= 1'b1;
        end else begin
            upd_q   <= update_dr;
            pulse_n <= !trig;
        end
    end

    p_single_period_r4: assert property (@(negedge tck) disable iff (rst)
        !pulse_n |=> pulse_n);

    p_only_at_update_r3: assert property (@(negedge tck) disable iff (rst)
        $fell(pulse_n) |-> $past(update_dr && sel));

endmodule

// File: rtl/gw_pulse_status_tdr.sv
module gw_pulse_status_tdr
    import gwtdr_pkg::*;
#(
    parameter int N_PORTS = 6,
    parameter int STAT_W  = 8,
    parameter int UCODE_W = 8,
    parameter int ID_W    = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5E_C0DB
) (
    input  logic               tck,
    input  logic               rst,
    input  logic [7:0]         ir_opcode,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               tlr,
    input  logic               tdi,
    input  logic [STAT_W-1:0]  status_pins,
    input  logic               local_rst_n,
    input  logic               wr_strobe_in,
    output logic               tdo_data,
    output logic               self_test_n,
    output logic [N_PORTS-1:0] port_trst_n,
    output logic [N_PORTS-1:0] wr_strobe_out,
    output logic [N_PORTS-1:0] wr_strobe_oe,
    output logic               wait_sel_req
);

    localparam int PULSE_STEST = 0;
    localparam int PULSE_LRST  = 1;

    tdr_sel_e  sel;
    dr_phase_t ph;

    assign sel = decode_op(ir_opcode);
    assign ph  = '{capture: capture_dr, shift: shift_dr, update: update_dr};

    logic [0:0]         byp_q;
    logic [ID_W-1:0]    id_q;
    logic [UCODE_W-1:0] ucode_q;
    logic [STAT_W-1:0]  stat_q;
    logic [N_PORTS-1:0] strobe_sr;
    logic [N_PORTS-1:0] strobe_en_q;

    gwtdr_shift #(.W(1)) u_byp (
        .tck(tck), .rst(rst), .en(sel == SEL_BYP), .ph(ph), .tdi(tdi),
        .cap_val(1'b0), .q(byp_q));

    gwtdr_shift #(.W(ID_W)) u_id (
        .tck(tck), .rst(rst), .en(sel == SEL_ID), .ph(ph), .tdi(tdi),
        .cap_val(ID_VALUE), .q(id_q));

    gwtdr_shift #(.W(UCODE_W)) u_ucode (
        .tck(tck), .rst(rst), .en(sel == SEL_UCODE), .ph(ph), .tdi(tdi),
        .cap_val({UCODE_W{1'b0}}), .q(ucode_q));

    gwtdr_shift #(.W(STAT_W)) u_stat (
        .tck(tck), .rst(rst), .en(sel == SEL_STATUS), .ph(ph), .tdi(tdi),
        .cap_val(status_pins), .q(stat_q));

    gwtdr_shift #(.W(N_PORTS)) u_strobe (
        .tck(tck), .rst(rst), .en(sel == SEL_STROBE), .ph(ph), .tdi(tdi),
        .cap_val(strobe_en_q), .q(strobe_sr));

    // Command trigger bits: each is a one-bit register feeding a pulse generator
    logic [N_PULSE-1:0] pulse_bit;
    logic [N_PULSE-1:0] pulse_n;

    for (genvar g = 0; g < N_PULSE; g++) begin : g_pulse
        localparam tdr_sel_e OWNER = pulse_owner(g);
        logic [0:0] bit_q;

        gwtdr_shift #(.W(1)) u_bit (
            .tck(tck), .rst(rst), .en(sel == OWNER), .ph(ph), .tdi(tdi),
            .cap_val(1'b0), .q(bit_q));

        assign pulse_bit[g] = bit_q[0];

        gwtdr_pulse u_gen (
            .tck(tck), .rst(rst), .sel(sel == OWNER), .update_dr(update_dr),
            .data_bit(pulse_bit[g]), .pulse_n(pulse_n[g]));
    end

    // Write-strobe enable mask, updated in the falling half of Update-DR
    always_ff @(negedge tck) begin
        if (rst || tlr) begin
            strobe_en_q <= '0;
        end else if (sel == SEL_STROBE && update_dr) begin
            strobe_en_q <= strobe_sr;
        end
    end

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        assign wr_strobe_oe[p]  = strobe_en_q[p];
        assign wr_strobe_out[p] = strobe_en_q[p] & wr_strobe_in;
        assign port_trst_n[p]   = pulse_n[PULSE_LRST] & local_rst_n;
    end

    assign self_test_n  = pulse_n[PULSE_STEST];
    assign wait_sel_req = !local_rst_n;

    always_comb begin
        case (sel)
            SEL_BYP:    tdo_data = byp_q[0];
            SEL_UCODE:  tdo_data = ucode_q[0];
            SEL_STATUS: tdo_data = stat_q[0];
            SEL_STROBE: tdo_data = strobe_sr[0];
            SEL_STEST:  tdo_data = pulse_bit[PULSE_STEST];
            SEL_LRST:   tdo_data = pulse_bit[PULSE_LRST];
            default:    tdo_data = id_q[0];
        endcase
    end

    p_local_reset_r6: assert property (@(posedge tck) disable iff (rst)
        !local_rst_n |-> (port_trst_n == '0 && wait_sel_req));

    p_tlr_clears_r8: assert property (@(negedge tck) disable iff (rst)
        tlr |=> (wr_strobe_oe == '0));

    p_mask_hold_r12: assert property (@(negedge tck) disable iff (rst)
        (!update_dr && !tlr) |=> $stable(wr_strobe_oe));

    p_pulses_apart_r5: assert property (@(negedge tck) disable iff (rst)
        !(pulse_n[PULSE_STEST] == 1'b0 && pulse_n[PULSE_LRST] == 1'b0));

endmodule

// File: tb/gw_pulse_status_tdr_tb.sv
module gw_pulse_status_tdr_tb;

    localparam int TCK_PERIOD = 10;
    localparam int NP = 6;
    localparam logic [31:0] ID_EXP = 32'h1A5E_C0DB;

    logic          tck = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    ir_opcode = 8'hFF;
    logic          capture_dr = 0, shift_dr = 0, update_dr = 0, tlr = 0, tdi = 0;
    logic [7:0]    status_pins = 8'h00;
    logic          local_rst_n = 1'b1;
    logic          wr_strobe_in = 1'b0;
    logic          tdo_data, self_test_n, wait_sel_req;
    logic [NP-1:0] port_trst_n, wr_strobe_out, wr_strobe_oe;

    int checks = 0;
    int fails  = 0;

    always #(TCK_PERIOD/2) tck = ~tck;

    gw_pulse_status_tdr #(.N_PORTS(NP), .ID_VALUE(ID_EXP)) u_dut (
        .tck(tck), .rst(rst), .ir_opcode(ir_opcode), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tlr(tlr), .tdi(tdi),
        .status_pins(status_pins), .local_rst_n(local_rst_n),
        .wr_strobe_in(wr_strobe_in), .tdo_data(tdo_data),
        .self_test_n(self_test_n), .port_trst_n(port_trst_n),
        .wr_strobe_out(wr_strobe_out), .wr_strobe_oe(wr_strobe_oe),
        .wait_sel_req(wait_sel_req));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Enter a TAP state just after the rising edge
    task automatic enter(input logic c, input logic s, input logic u, input logic t);
        @(posedge tck); #1;
        capture_dr = c; shift_dr = s; update_dr = u; tlr = t;
    endtask

    // Move to just after the falling edge inside the current state
    task automatic mid();
        @(negedge tck); #1;
    endtask

    task automatic idle();
        enter(0, 0, 0, 0); mid();
    endtask

    // Full DR scan; returns after the falling edge of Update-DR
    task automatic scan(input logic [7:0] op, input int w, input logic [31:0] din,
                        output logic [31:0] dout);
        dout = '0;
        enter(0, 0, 0, 0); ir_opcode = op; mid();
        enter(1, 0, 0, 0); mid();
        for (int i = 0; i < w; i++) begin
            enter(0, 1, 0, 0); tdi = din[i]; mid();
            dout[i] = tdo_data;
        end
        enter(0, 0, 0, 0); tdi = 1'b0; mid();
        enter(0, 0, 1, 0); mid();
    endtask

    task automatic t_reset();
        chk("R1 self_test_n", {31'b0, self_test_n}, 32'h1);
        chk("R1 port_trst_n", {26'b0, port_trst_n}, 32'h3F);
        chk("R1 wr_strobe_oe", {26'b0, wr_strobe_oe}, 32'h0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        status_pins = 8'hA6;
        scan(8'h9A, 8, 32'h0, d); idle();
        chk("R2 status A6", d, 32'hA6);
        status_pins = 8'h5B;
        scan(8'h9A, 8, 32'hFF, d); idle();
        chk("R2 status 5B", d, 32'h5B);
    endtask

    task automatic t_selftest();
        logic [31:0] d;
        scan(8'h99, 1, 32'h0, d);
        chk("R3 capture zero", d, 32'h0);
        chk("R3 pulse low", {31'b0, self_test_n}, 32'h0);
        chk("R5 trst untouched by self-test", {26'b0, port_trst_n}, 32'h3F);
        idle();
        chk("R3 pulse released", {31'b0, self_test_n}, 32'h1);
        scan(8'h99, 1, 32'h1, d);
        chk("R3 one shifted in suppresses", {31'b0, self_test_n}, 32'h1);
        idle();
    endtask

    task automatic t_hold();
        logic [31:0] d;
        scan(8'h99, 1, 32'h0, d);
        chk("R4 held update first", {31'b0, self_test_n}, 32'h0);
        enter(0, 0, 1, 0); mid();
        chk("R4 held update second", {31'b0, self_test_n}, 32'h1);
        enter(0, 0, 1, 0); mid();
        chk("R4 held update third", {31'b0, self_test_n}, 32'h1);
        idle();
    endtask

    task automatic t_lrst();
        logic [31:0] d;
        scan(8'h9B, 1, 32'h0, d);
        chk("R5 trst pulse", {26'b0, port_trst_n}, 32'h0);
        chk("R5 self-test quiet", {31'b0, self_test_n}, 32'h1);
        idle();
        chk("R5 trst released", {26'b0, port_trst_n}, 32'h3F);
    endtask

    task automatic t_local();
        enter(0, 0, 0, 0); local_rst_n = 1'b0; mid();
        chk("R6 trst low", {26'b0, port_trst_n}, 32'h0);
        chk("R6 wait request", {31'b0, wait_sel_req}, 32'h1);
        enter(0, 0, 0, 0); local_rst_n = 1'b1; mid();
        chk("R6 trst high after release", {26'b0, port_trst_n}, 32'h3F);
        chk("R6 wait request off", {31'b0, wait_sel_req}, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        local_rst_n = 1'b0;
        scan(8'h9B, 1, 32'h0, d);
        chk("R6 overlap at update", {26'b0, port_trst_n}, 32'h0);
        idle();
        chk("R6 overlap after pulse", {26'b0, port_trst_n}, 32'h0);
        enter(0, 0, 0, 0); local_rst_n = 1'b1; mid();
        chk("R6 overlap released", {26'b0, port_trst_n}, 32'h3F);
        scan(8'h9B, 1, 32'h0, d);
        chk("R5 pulse after overlap", {26'b0, port_trst_n}, 32'h0);
        idle();
        chk("R4 pulse after overlap ends", {26'b0, port_trst_n}, 32'h3F);
    endtask

    task automatic t_strobe();
        logic [31:0] d;
        wr_strobe_in = 1'b1;
        scan(8'h98, 6, 32'h25, d);
        chk("R7 readback before write", d, 32'h0);
        chk("R7 oe after update", {26'b0, wr_strobe_oe}, 32'h25);
        chk("R7 out follows strobe high", {26'b0, wr_strobe_out}, 32'h25);
        idle();
        wr_strobe_in = 1'b0; #1;
        chk("R7 out follows strobe low", {26'b0, wr_strobe_out}, 32'h0);
        scan(8'h98, 6, 32'h1A, d);
        chk("R7 readback", d, 32'h25);
        chk("R7 second write", {26'b0, wr_strobe_oe}, 32'h1A);
        idle();
    endtask

    task automatic t_tlr();
        enter(0, 0, 0, 1); mid();
        chk("R8 tlr clears mask", {26'b0, wr_strobe_oe}, 32'h0);
        idle();
    endtask

    task automatic t_ucode();
        logic [31:0] d;
        scan(8'h97, 8, 32'hFF, d); idle();
        chk("R9 user code zero", d, 32'h0);
        scan(8'h97, 8, 32'h3C, d); idle();
        chk("R9 user code not writable", d, 32'h0);
    endtask

    task automatic t_bypass();
        logic [31:0] d;
        scan(8'hFF, 4, 32'hD, d); idle();
        chk("R10 bypass delay", d, 32'hA);
    endtask

    task automatic t_id();
        logic [31:0] d;
        scan(8'h00, 32, 32'h0, d); idle();
        chk("R11 id for 00", d, ID_EXP);
        scan(8'hAA, 32, 32'hFFFF_FFFF, d); idle();
        chk("R11 id for AA", d, ID_EXP);
    endtask

    task automatic t_nosel();
        logic [31:0] d;
        scan(8'h98, 6, 32'h3F, d); idle();
        scan(8'h9A, 8, 32'h0, d);
        chk("R12 mask kept", {26'b0, wr_strobe_oe}, 32'h3F);
        chk("R12 no self-test", {31'b0, self_test_n}, 32'h1);
        chk("R12 no trst", {26'b0, port_trst_n}, 32'h3F);
        idle();
    endtask

    initial begin
        #(TCK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) enter(0, 0, 0, 0);
        mid();
        enter(0, 0, 0, 0); rst = 1'b0; mid();
        t_reset();
        t_status();
        t_selftest();
        t_hold();
        t_lrst();
        t_local();
        t_collision();
        t_strobe();
        t_tlr();
        t_ucode();
        t_bypass();
        t_id();
        t_nosel();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule